// File: doc/BRIEF.md
# Hotplug Event Register Block

This block gathers hotplug signalling for processors and PCI slots into one byte-addressed register space. Hardware reports a processor coming or going, or a slot gaining or losing a card. The block records the change in a presence bitmap or in a pair of slot bitmaps, raises a dedicated event status bit and emits a one-cycle system control interrupt pulse. Firmware then reads the bitmaps to find out what changed and acknowledges the event by clearing the status bit.

Status and enable are each 16 bits wide and are reached one byte at a time. Status lanes are write-one-to-clear and enable lanes are plain writes. Firmware asks for a slot to be removed by writing a byte to the eject window. The slot is named by the lowest set bit of that byte, offset by the byte's lane, and the block answers with a one-cycle eject strobe that carries the slot number.

Address map (byte addresses): processor presence 0x00 to CPU_BYTES-1; status low/high at 0x40/0x41; enable low/high at 0x42/0x43; slot-added bitmap 0x50..0x53; slot-removed bitmap 0x54..0x57; eject window 0x58..0x5B. Reads of unmapped addresses return 0 and writes to them do nothing. Read data is combinational from `addr`.

Top module: `hp_event_regs`

## Requirements
- R1: Status and enable are 16 bits each. Address bit 0 picks the lane: even addresses read and write bits 7:0, odd addresses bits 15:8.
- R2: A byte write to status (0x40/0x41) clears exactly the bits written as 1 in the addressed lane and leaves the other lane alone.
- R3: A byte write to enable (0x42/0x43) replaces the addressed lane only.
- R4: Processor n is reported at byte n/8, bit n%8 of the presence area. Writes to the presence area have no effect.
- R5: After reset, the presence bits of processors 0 to NUM_CPUS-1 are 1 and all others are 0. With NUM_CPUS=12 this gives byte0=0xFF, byte1=0x0F, byte2=0x00.
- R6: A processor event with add=1 sets that processor's presence bit, and with add=0 clears it, one clock after the event.
- R7: A slot event clears both slot bitmaps and then sets the slot's bit in the added map (insertion) or in the removed map (removal). Bus writes to either bitmap have no effect.
- R8: Every clock with a processor or slot event (or both) gives exactly one high cycle on `sci_pulse` on the next clock. Clocks without events leave it low.
- R9: A processor event sets status bit 2 and a slot event sets status bit 1. A clearing write to that bit in the same clock loses to the event.
- R10: A nonzero byte written to eject byte k (0x58+k) raises `eject_valid` for one clock on the next clock, with `eject_slot` = 8*k + index of the lowest set bit.
- R11: Writing 0 to the eject window raises no strobe, and the eject window reads as 0.
- R12: After reset, status, enable and both slot bitmaps are 0, and `sci_pulse` and `eject_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| cpu_evt_valid | input | 1 | Processor hotplug event |
| cpu_evt_id | input | $clog2(CPU_BYTES*8) | Processor number |
| cpu_evt_add | input | 1 | 1 = processor added, 0 = removed |
| slot_evt_valid | input | 1 | Slot hotplug event |
| slot_evt_id | input | $clog2(SLOTS) | Slot number |
| slot_evt_add | input | 1 | 1 = insertion, 0 = removal |
| sci_pulse | output | 1 | One-cycle interrupt pulse |
| eject_valid | output | 1 | One-cycle eject strobe |
| eject_slot | output | $clog2(SLOTS) | Slot to eject |

## Verification
The hardest case to reach from the ports is the collision of an event with a clearing write to the status bit that the event sets, in the same clock. A clean drain of the status register leaves no window in which to see this. The bench therefore drives a processor event, a slot event and a clearing write to status lane 0 in a single cycle, then expects one SCI pulse and both status bits still set. Eject lanes other than lane 0, with several bits set, check that the lane offset and the lowest-bit priority combine correctly.

// File: rtl/hp_pkg.sv
package hp_pkg;
   localparam logic [7:0] HP_CPU_BASE = 8'h00;
   localparam logic [7:0] HP_GPE_BASE = 8'h40;
   localparam logic [7:0] HP_UP_BASE  = 8'h50;
   localparam logic [7:0] HP_DN_BASE  = 8'h54;
   localparam logic [7:0] HP_EJ_BASE  = 8'h58;

   localparam int unsigned HP_STS_PCI_BIT = 1;
   localparam int unsigned HP_STS_CPU_BIT = 2;

   function automatic logic [2:0] hp_low_bit(input logic [7:0] v);
      logic [2:0] idx;
      idx = 3'd0;
      for (int i = 7; i >= 0; i--) begin
         if (v[i]) idx = 3'(i);
      end
      return idx;
   endfunction
endpackage

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs
   import hp_pkg::*;
#(
   parameter int unsigned GPE_W = 16,
   localparam int unsigned LANES = GPE_W / 8,
   localparam int unsigned LW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             sel_sts,
   input  logic             sel_en,
   input  logic [LW-1:0]    lane,
   input  logic [7:0]       wdata,
   input  logic             set_cpu,
   input  logic             set_pci,
   output logic [GPE_W-1:0] sts_q,
   output logic [GPE_W-1:0] en_q,
   output logic             sci_q
);
   logic [GPE_W-1:0] set_mask;

   always_comb begin
      set_mask = '0;
      set_mask[HP_STS_CPU_BIT] = set_cpu;
      set_mask[HP_STS_PCI_BIT] = set_pci;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic       hit;
      logic [7:0] sts_l;
      logic [7:0] en_l;
      logic [7:0] clr;

      assign hit = (lane == LW'(l));
      assign clr = (wr_en && sel_sts && hit) ? wdata : 8'h00;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sts_l <= 8'h00;
            en_l  <= 8'h00;
         end else begin
            sts_l <= (sts_l & ~clr) | set_mask[l*8 +: 8];
            if (wr_en && sel_en && hit) en_l <= wdata;
         end
      end

      assign sts_q[l*8 +: 8] = sts_l;
      assign en_q[l*8 +: 8]  = en_l;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sci_q <= 1'b0;
      else        sci_q <= set_cpu | set_pci;
   end
endmodule

// File: rtl/hp_cpu_map.sv
module hp_cpu_map #(
   parameter int unsigned CPU_BYTES = 32,
   parameter int unsigned NUM_CPUS  = 12,
   localparam int unsigned PW   = CPU_BYTES * 8,
   localparam int unsigned ID_W = $clog2(PW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            evt_valid,
   input  logic [ID_W-1:0] evt_id,
   input  logic            evt_add,
   output logic [PW-1:0]   pres_q
);
   function automatic logic [PW-1:0] boot_mask();
      logic [PW-1:0] v;
      for (int i = 0; i < PW; i++) v[i] = (i < NUM_CPUS);
      return v;
   endfunction

   localparam logic [PW-1:0] BOOT = boot_mask();

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pres_q <= BOOT;
      else if (evt_valid) pres_q[evt_id] <= evt_add;
   end
endmodule

// File: rtl/hp_slot_map.sv
module hp_slot_map
   import hp_pkg::*;
#(
   parameter int unsigned SLOTS = 32,
   localparam int unsigned SB    = SLOTS / 8,
   localparam int unsigned SB_W  = (SB > 1) ? $clog2(SB) : 1,
   localparam int unsigned SID_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_valid,
   input  logic [SID_W-1:0] evt_id,
   input  logic             evt_add,
   input  logic             ej_wr,
   input  logic [SB_W-1:0]  ej_lane,
   input  logic [7:0]       ej_data,
   output logic [SLOTS-1:0] up_q,
   output logic [SLOTS-1:0] dn_q,
   output logic             ej_valid,
   output logic [SID_W-1:0] ej_slot
);
   logic [SLOTS-1:0] onehot;
   logic [SID_W-1:0] ej_slot_d;

   assign onehot    = SLOTS'(1) << evt_id;
   assign ej_slot_d = SID_W'({ej_lane, hp_low_bit(ej_data)});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= '0;
         dn_q <= '0;
      end else if (evt_valid) begin
         up_q <= evt_add ? onehot : '0;
         dn_q <= evt_add ? '0 : onehot;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ej_valid <= 1'b0;
         ej_slot  <= '0;
      end else begin
         ej_valid <= ej_wr && (ej_data != 8'h00);
         if (ej_wr && (ej_data != 8'h00)) ej_slot <= ej_slot_d;
      end
   end
endmodule

// File: rtl/hp_event_regs.sv
module hp_event_regs
   import hp_pkg::*;
#(
   parameter int unsigned CPU_BYTES = 32,
   parameter int unsigned NUM_CPUS  = 12,
   parameter int unsigned SLOTS     = 32,
   parameter int unsigned GPE_W     = 16,
   localparam int unsigned CID_W = $clog2(CPU_BYTES * 8),
   localparam int unsigned SID_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   input  logic             cpu_evt_valid,
   input  logic [CID_W-1:0] cpu_evt_id,
   input  logic             cpu_evt_add,
   input  logic             slot_evt_valid,
   input  logic [SID_W-1:0] slot_evt_id,
   input  logic             slot_evt_add,
   output logic             sci_pulse,
   output logic             eject_valid,
   output logic [SID_W-1:0] eject_slot
);
   localparam int unsigned SB    = SLOTS / 8;
   localparam int unsigned SB_W  = (SB > 1) ? $clog2(SB) : 1;
   localparam int unsigned CB_W  = (CPU_BYTES > 1) ? $clog2(CPU_BYTES) : 1;
   localparam logic [8:0]  CPU_END = 9'(CPU_BYTES);
   localparam logic [8:0]  SB9     = 9'(SB);

   if (GPE_W != 16) begin : g_bad_gpe
      $error("GPE_W must be 16");
   end
   if (!(SLOTS == 8 || SLOTS == 16 || SLOTS == 32)) begin : g_bad_slots
      $error("SLOTS must be 8, 16 or 32");
   end
   if (CPU_BYTES < 2 || CPU_BYTES > 64 || (CPU_BYTES & (CPU_BYTES - 1)) != 0) begin : g_bad_cpu
      $error("CPU_BYTES must be a power of two in 2..64");
   end
   if (NUM_CPUS > CPU_BYTES * 8) begin : g_bad_num
      $error("NUM_CPUS exceeds presence area");
   end

   logic [CPU_BYTES*8-1:0] cpu_bits;
   logic [SLOTS-1:0]       slot_up;
   logic [SLOTS-1:0]       slot_dn;
   logic [GPE_W-1:0]       gpe_sts;
   logic [GPE_W-1:0]       gpe_en;

   logic       hit_cpu, hit_gpe, hit_up, hit_dn, hit_ej;
   logic [8:0] off_up, off_dn, off_ej;

   assign off_up  = {1'b0, addr} - {1'b0, HP_UP_BASE};
   assign off_dn  = {1'b0, addr} - {1'b0, HP_DN_BASE};
   assign off_ej  = {1'b0, addr} - {1'b0, HP_EJ_BASE};
   assign hit_cpu = ({1'b0, addr} < CPU_END);
   assign hit_gpe = (addr[7:2] == HP_GPE_BASE[7:2]);
   assign hit_up  = (addr >= HP_UP_BASE) && (off_up < SB9);
   assign hit_dn  = (addr >= HP_DN_BASE) && (off_dn < SB9);
   assign hit_ej  = (addr >= HP_EJ_BASE) && (off_ej < SB9);

   hp_gpe_regs #(.GPE_W(GPE_W)) u_gpe (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .sel_sts (hit_gpe && !addr[1]),
      .sel_en  (hit_gpe && addr[1]),
      .lane    (addr[0:0]),
      .wdata   (wdata),
      .set_cpu (cpu_evt_valid),
      .set_pci (slot_evt_valid),
      .sts_q   (gpe_sts),
      .en_q    (gpe_en),
      .sci_q   (sci_pulse)
   );

   hp_cpu_map #(.CPU_BYTES(CPU_BYTES), .NUM_CPUS(NUM_CPUS)) u_cpu (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_valid (cpu_evt_valid),
      .evt_id    (cpu_evt_id),
      .evt_add   (cpu_evt_add),
      .pres_q    (cpu_bits)
   );

   hp_slot_map #(.SLOTS(SLOTS)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_valid (slot_evt_valid),
      .evt_id    (slot_evt_id),
      .evt_add   (slot_evt_add),
      .ej_wr     (wr_en && hit_ej),
      .ej_lane   (off_ej[SB_W-1:0]),
      .ej_data   (wdata),
      .up_q      (slot_up),
      .dn_q      (slot_dn),
      .ej_valid  (eject_valid),
      .ej_slot   (eject_slot)
   );

   logic [7:0] cpu_b [CPU_BYTES];
   logic [7:0] up_b  [SB];
   logic [7:0] dn_b  [SB];

   for (genvar b = 0; b < CPU_BYTES; b++) begin : g_cpu_b
      assign cpu_b[b] = cpu_bits[b*8 +: 8];
   end
   for (genvar b = 0; b < SB; b++) begin : g_slot_b
      assign up_b[b] = slot_up[b*8 +: 8];
      assign dn_b[b] = slot_dn[b*8 +: 8];
   end

   always_comb begin
      rdata = 8'h00;
      if (hit_cpu) begin
         rdata = cpu_b[addr[CB_W-1:0]];
      end else if (hit_gpe) begin
         if (addr[1]) rdata = addr[0] ? gpe_en[15:8]  : gpe_en[7:0];
         else         rdata = addr[0] ? gpe_sts[15:8] : gpe_sts[7:0];
      end else if (hit_up) begin
         rdata = up_b[off_up[SB_W-1:0]];
      end else if (hit_dn) begin
         rdata = dn_b[off_dn[SB_W-1:0]];
      end
   end
endmodule

// File: rtl/hp_event_chk.sv
module hp_event_chk
   import hp_pkg::*;
#(
   parameter int unsigned PW = 256,
   parameter int unsigned SW = 32,
   parameter int unsigned GW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [7:0]    addr,
   input logic [7:0]    wdata,
   input logic          cpu_evt_valid,
   input logic          slot_evt_valid,
   input logic          sci_pulse,
   input logic          eject_valid,
   input logic [PW-1:0] pres,
   input logic [SW-1:0] up,
   input logic [SW-1:0] dn,
   input logic [GW-1:0] sts
);
   logic ej_hit;
   assign ej_hit = (addr >= HP_EJ_BASE) && ({1'b0, addr} < ({1'b0, HP_EJ_BASE} + 9'(SW / 8)));

   // R8
   sci_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_evt_valid || slot_evt_valid) |=> sci_pulse);
   // R8
   sci_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_evt_valid || slot_evt_valid) |=> !sci_pulse);
   // R4
   pres_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_evt_valid |=> $stable(pres));
   // R7
   slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_evt_valid |=> ($countones({up, dn}) == 1));
   // R7
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_evt_valid |=> ($stable(up) && $stable(dn)));
   // R9
   cpu_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_evt_valid |=> sts[HP_STS_CPU_BIT]);
   // R9
   pci_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_evt_valid |=> sts[HP_STS_PCI_BIT]);
   // R10
   eject_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ej_hit && wdata != 8'h00) |=> eject_valid);
   // R11
   eject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && ej_hit && wdata != 8'h00) |=> !eject_valid);
endmodule

bind hp_event_regs hp_event_chk #(.PW(CPU_BYTES*8), .SW(SLOTS), .GW(GPE_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .addr           (addr),
   .wdata          (wdata),
   .cpu_evt_valid  (cpu_evt_valid),
   .slot_evt_valid (slot_evt_valid),
   .sci_pulse      (sci_pulse),
   .eject_valid    (eject_valid),
   .pres           (cpu_bits),
   .up             (slot_up),
   .dn             (slot_dn),
   .sts            (gpe_sts)
);

// File: tb/sim_hp_event_regs.sv
module sim_hp_event_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       cpu_evt_valid = 1'b0;
   logic [7:0] cpu_evt_id = 8'h00;
   logic       cpu_evt_add = 1'b0;
   logic       slot_evt_valid = 1'b0;
   logic [4:0] slot_evt_id = 5'd0;
   logic       slot_evt_add = 1'b0;
   logic       sci_pulse;
   logic       eject_valid;
   logic [4:0] eject_slot;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   string cur_req = "R12";

   // reference model state
   int m_cpu [256];
   int m_up  [32];
   int m_dn  [32];
   int m_sts = 0;
   int m_en  = 0;
   int m_sci = 0;
   int m_ejv = 0;
   int m_ejs = 0;

   always #4 clk = ~clk;

   hp_event_regs u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .cpu_evt_valid(cpu_evt_valid), .cpu_evt_id(cpu_evt_id), .cpu_evt_add(cpu_evt_add),
      .slot_evt_valid(slot_evt_valid), .slot_evt_id(slot_evt_id), .slot_evt_add(slot_evt_add),
      .sci_pulse(sci_pulse), .eject_valid(eject_valid), .eject_slot(eject_slot)
   );

   task automatic model_reset();
      for (int i = 0; i < 256; i++) m_cpu[i] = (i < 12) ? 1 : 0;
      for (int i = 0; i < 32; i++) begin m_up[i] = 0; m_dn[i] = 0; end
      m_sts = 0; m_en = 0; m_sci = 0; m_ejv = 0; m_ejs = 0;
   endtask

   function automatic int m_read(input int a);
      int v;
      v = 0;
      if (a < 32) begin
         for (int i = 0; i < 8; i++) v += m_cpu[a*8+i] << i;
      end else if (a == 'h40) v = m_sts & 'hff;
      else if (a == 'h41) v = (m_sts >> 8) & 'hff;
      else if (a == 'h42) v = m_en & 'hff;
      else if (a == 'h43) v = (m_en >> 8) & 'hff;
      else if (a >= 'h50 && a < 'h54) begin
         for (int i = 0; i < 8; i++) v += m_up[(a-'h50)*8+i] << i;
      end else if (a >= 'h54 && a < 'h58) begin
         for (int i = 0; i < 8; i++) v += m_dn[(a-'h54)*8+i] << i;
      end
      return v;
   endfunction

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         m_sci = (cpu_evt_valid || slot_evt_valid) ? 1 : 0;
         m_ejv = 0;
         if (wr_en) begin
            if (addr == 8'h40) m_sts = m_sts & ~int'(wdata);
            if (addr == 8'h41) m_sts = m_sts & ~(int'(wdata) << 8);
            if (addr == 8'h42) m_en = (m_en & 'hff00) | int'(wdata);
            if (addr == 8'h43) m_en = (m_en & 'h00ff) | (int'(wdata) << 8);
            if (addr >= 8'h58 && addr < 8'h5c && wdata != 0) begin
               int lo;
               lo = -1;
               for (int i = 0; i < 8; i++) if (lo < 0 && wdata[i]) lo = i;
               m_ejv = 1;
               m_ejs = (int'(addr) - 'h58) * 8 + lo;
            end
         end
         if (cpu_evt_valid) begin
            m_cpu[cpu_evt_id] = cpu_evt_add ? 1 : 0;
            m_sts = m_sts | 4;
         end
         if (slot_evt_valid) begin
            for (int i = 0; i < 32; i++) begin m_up[i] = 0; m_dn[i] = 0; end
            if (slot_evt_add) m_up[slot_evt_id] = 1; else m_dn[slot_evt_id] = 1;
            m_sts = m_sts | 2;
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, "sci_pulse", int'(sci_pulse), m_sci);
         check(cur_req, "eject_valid", int'(eject_valid), m_ejv);
         if (m_ejv != 0) check(cur_req, "eject_slot", int'(eject_slot), m_ejs);
         check(cur_req, "rdata", int'(rdata), m_read(int'(addr)));
      end
   end

   task automatic rd_chk(input int a, input int exp, input string req);
      @(negedge clk); #1 addr = 8'(a);
      @(negedge clk);
      check(req, $sformatf("read 0x%0h", a), int'(rdata), exp);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk); #1 wr_en = 1'b1; addr = 8'(a); wdata = 8'(d);
      @(negedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic ej_chk(input int a, input int d, input int exp_v, input int exp_s, input string req);
      @(negedge clk); #1 wr_en = 1'b1; addr = 8'(a); wdata = 8'(d);
      @(negedge clk);
      check(req, "eject strobe", int'(eject_valid), exp_v);
      if (exp_v != 0) check(req, "eject slot", int'(eject_slot), exp_s);
      #1 wr_en = 1'b0;
      @(negedge clk);
      check(req, "eject strobe drop", int'(eject_valid), 0);
   endtask

   task automatic cpu_ev(input int id, input bit add);
      @(negedge clk); #1 cpu_evt_valid = 1'b1; cpu_evt_id = 8'(id); cpu_evt_add = add;
      @(negedge clk);
      check("R8", "sci after cpu event", int'(sci_pulse), 1);
      #1 cpu_evt_valid = 1'b0;
      @(negedge clk);
      check("R8", "sci one cycle", int'(sci_pulse), 0);
   endtask

   task automatic slot_ev(input int id, input bit add);
      @(negedge clk); #1 slot_evt_valid = 1'b1; slot_evt_id = 5'(id); slot_evt_add = add;
      @(negedge clk);
      check("R8", "sci after slot event", int'(sci_pulse), 1);
      #1 slot_evt_valid = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         bad++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      // R12 reset state
      check("R12", "sci at reset", int'(sci_pulse), 0);
      check("R12", "eject at reset", int'(eject_valid), 0);
      rd_chk('h40, 0, "R12");
      rd_chk('h43, 0, "R12");
      rd_chk('h50, 0, "R12");
      // R5 boot presence pattern
      cur_req = "R5";
      rd_chk('h00, 'hff, "R5");
      rd_chk('h01, 'h0f, "R5");
      rd_chk('h02, 'h00, "R5");
      // R3 / R1 enable lanes
      cur_req = "R3";
      wr('h42, 'ha5);
      rd_chk('h42, 'ha5, "R3");
      rd_chk('h43, 'h00, "R1");
      wr('h43, 'h3c);
      rd_chk('h43, 'h3c, "R1");
      rd_chk('h42, 'ha5, "R3");
      // R6 / R9 processor add
      cur_req = "R6";
      cpu_ev(20, 1'b1);
      rd_chk('h02, 'h10, "R6");
      rd_chk('h40, 'h04, "R9");
      // R2 lane-local clear
      cur_req = "R2";
      wr('h41, 'hff);
      rd_chk('h40, 'h04, "R2");
      wr('h40, 'h04);
      rd_chk('h40, 'h00, "R2");
      // R7 slot events
      cur_req = "R7";
      slot_ev(5, 1'b1);
      rd_chk('h50, 'h20, "R7");
      rd_chk('h40, 'h02, "R9");
      slot_ev(9, 1'b0);
      rd_chk('h50, 'h00, "R7");
      rd_chk('h55, 'h02, "R7");
      wr('h55, 'hff);
      rd_chk('h55, 'h02, "R7");
      // R4 presence ignores writes
      cur_req = "R4";
      wr('h02, 'h00);
      rd_chk('h02, 'h10, "R4");
      cpu_ev(3, 1'b0);
      rd_chk('h00, 'hf7, "R6");
      // R10 / R11 eject
      cur_req = "R10";
      ej_chk('h59, 'h18, 1, 11, "R10");
      ej_chk('h5b, 'h80, 1, 31, "R10");
      ej_chk('h58, 'h01, 1, 0, "R10");
      cur_req = "R11";
      ej_chk('h58, 'h00, 0, 0, "R11");
      rd_chk('h59, 'h00, "R11");
      // R9 event beats a same-cycle clear; both events give one pulse
      cur_req = "R9";
      wr('h40, 'hff);
      rd_chk('h40, 'h00, "R2");
      @(negedge clk);
      #1 wr_en = 1'b1; addr = 8'h40; wdata = 8'h06;
      cpu_evt_valid = 1'b1; cpu_evt_id = 8'd40; cpu_evt_add = 1'b1;
      slot_evt_valid = 1'b1; slot_evt_id = 5'd31; slot_evt_add = 1'b1;
      @(negedge clk);
      check("R8", "single sci for two events", int'(sci_pulse), 1);
      #1 wr_en = 1'b0; cpu_evt_valid = 1'b0; slot_evt_valid = 1'b0;
      @(negedge clk);
      check("R8", "sci drops", int'(sci_pulse), 0);
      rd_chk('h40, 'h06, "R9");
      rd_chk('h05, 'h01, "R6");
      rd_chk('h53, 'h80, "R7");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule